// File: doc/BRIEF.md
# Banked Register File Address Decoder

This block is the data-store front end of a small 8-bit controller core. On each instruction it takes a 7-bit file address from the instruction word and resolves it to one byte of a compact physical register array. There are two ways to resolve it. A direct access puts the bank-select bit above the 7-bit field. An access to file offset 00h is indirect: it uses the full 8-bit pointer register in place of the field and the bank bit. Core special registers and general-purpose RAM appear at the same offset in both banks. A small group of bank-specific registers is stored separately for each bank. Every other location reads as zero and ignores writes.

The block runs a fixed four-phase access cycle. The address is decoded in the first phase and the array is read in the second. The third phase is left to the ALU. The result is written back in the fourth. The bank bit lives in bit 5 of the status register, which is part of the array. A status write therefore moves the bank at the write-back edge, and the next decode already uses the new bank. Peripheral behaviour behind the special registers is not modelled: they are plain storage.

Top module: `banked_file_decoder`

## Requirements
- R1: A synchronous active-low reset clears every stored byte to 00h, so every file reads 00h and the bank output is 0. During reset the phase output holds 0.
- R2: The phase output steps 0 (decode), 1 (read), 2 (ALU), 3 (write) on successive clocks and wraps to 0, starting at 0 on the first clock after reset is released.
- R3: A direct access (field not 00h) uses the effective address {bank bit, 7-bit field}, so bank 0 covers 00h-7Fh and bank 1 covers 80h-FFh.
- R4: A field of 00h is indirect. The effective address is the whole 8-bit pointer register (offset 04h), and the bank bit is ignored.
- R5: An indirect access whose pointer is 00h or 80h reads 00h, and a write through it changes no stored byte.
- R6: Offsets 02h, 03h, 04h, 0Ah and 0Bh are core registers, each with one storage byte reached from both banks.
- R7: Offsets 0Ch-4Fh are 68 general-purpose bytes, each reached from both banks (for example 4Fh and CFh).
- R8: Offsets 05h, 06h, 08h and 09h hold separate storage in each bank.
- R9: Offsets 01h, 07h and 50h-7Fh are unimplemented in both banks: they read 00h and writes to them are ignored.
- R10: The address and write request are sampled only in phase 0, and the write data only in phase 3. Read data updates at the end of phase 1 and holds until the next end of phase 1. A write takes effect at the end of phase 3.
- R11: The bank bit is bit 5 of the status register (offset 03h). The bank output shows it and changes only at the end of phase 3, and the following access decodes with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one phase per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_addr | input | 7 | File address field of the instruction, sampled in phase 0 |
| acc_wr | input | 1 | Write-back request for this access, sampled in phase 0 |
| wr_data | input | 8 | Result to write back, sampled in phase 3 |
| rd_data | output | 8 | Operand read from the resolved file, valid from phase 2 |
| phase_o | output | 2 | Current phase: 0 decode, 1 read, 2 ALU, 3 write |
| bank_sel_o | output | 1 | Current bank-select bit (status bit 5) |

## Verification
Two pairs of functions can meet in one access. The first is a status write that flips the bank followed at once by a direct access: the next decode must already use the new bank. The second is an indirect write whose pointer targets the pointer register itself: the write must land in the pointer, and the following indirect access must follow the new value. Directed sequences set up both cases. Seeded random accesses then mix random writes to status and the pointer with random direct and indirect traffic. A bench model resolves every access by the rules above and compares each read, and the bank output after each access.

// File: rtl/rfd_pkg.sv
// Package rfd_pkg
// Shared phase type, sizes and the logical-to-physical file map of the
// banked register file. Assumes an 8-bit data path and a 7-bit file field.
package rfd_pkg;

    localparam int DATA_W     = 8;
    localparam int FIELD_W    = 7;
    localparam int EADDR_W    = FIELD_W + 1;

    // Physical layout: core registers, then per-bank registers, then RAM
    localparam int N_CORE     = 5;
    localparam int N_BANKED   = 4;
    localparam int N_BANKS    = 2;
    localparam int GPR_LO     = 12;
    localparam int GPR_HI     = 79;
    localparam int N_GPR      = GPR_HI - GPR_LO + 1;
    localparam int BANKED_BASE = N_CORE;
    localparam int GPR_BASE   = N_CORE + N_BANKED * N_BANKS;
    localparam int N_PHYS     = GPR_BASE + N_GPR;
    localparam int IDX_W      = $clog2(N_PHYS);

    // Physical slots of the two registers the decoder itself depends on
    localparam int IDX_STATUS = 1;
    localparam int IDX_PTR    = 2;
    localparam int BANK_BIT   = 5;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_ALU    = 2'd2,
        PH_WRITE  = 2'd3
    } phase_e;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } loc_t;

    // Resolve an 8-bit effective address to a physical slot (or a miss)
    function automatic loc_t map_loc(input logic [EADDR_W-1:0] ea);
        loc_t r;
        int   off;
        int   bank;
        off  = int'(ea[FIELD_W-1:0]);
        bank = int'(ea[FIELD_W]);
        r    = '0;
        case (off)
            2:       begin r.hit = 1'b1; r.idx = IDX_W'(0); end
            3:       begin r.hit = 1'b1; r.idx = IDX_W'(IDX_STATUS); end
            4:       begin r.hit = 1'b1; r.idx = IDX_W'(IDX_PTR); end
            10:      begin r.hit = 1'b1; r.idx = IDX_W'(3); end
            11:      begin r.hit = 1'b1; r.idx = IDX_W'(4); end
            5, 6:    begin r.hit = 1'b1;
                           r.idx = IDX_W'(BANKED_BASE + bank * N_BANKED + off - 5); end
            8, 9:    begin r.hit = 1'b1;
                           r.idx = IDX_W'(BANKED_BASE + bank * N_BANKED + off - 6); end
            default: begin
                if (off >= GPR_LO && off <= GPR_HI) begin
                    r.hit = 1'b1;
                    r.idx = IDX_W'(GPR_BASE + off - GPR_LO);
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rfd_phase.sv
// Module rfd_phase
// Four-phase access sequencer: decode, read, ALU, write, then repeat.
// Assumes one phase per clock and a synchronous active-low reset to decode.
module rfd_phase
    import rfd_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase
);

    // Advance one phase per clock, wrapping from write back to decode
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_DECODE;
        else        phase <= phase_e'(phase + 2'd1);
    end

    // R2: a write phase is always followed by a decode phase
    a_r2_wrap_to_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE) |=> (phase == PH_DECODE));

endmodule

// File: rtl/rfd_decode.sv
// Module rfd_decode
// Combinational address resolution. A field of zero selects the indirect
// path through the pointer register; otherwise the bank bit is prepended.
// Assumes ptr and bank come from stored state that is stable in decode.
module rfd_decode
    import rfd_pkg::*;
#(
    parameter int FW = FIELD_W
) (
    input  logic [FW-1:0] field,
    input  logic          bank,
    input  logic [FW:0]   ptr,
    output loc_t          loc
);

    logic          indirect;
    logic [FW:0]   eff;

    // Choose between the pointer and the banked direct address
    always_comb begin
        indirect = (field == '0);
        eff      = indirect ? ptr : {bank, field};
        loc      = map_loc(eff);
    end

endmodule

// File: rtl/rfd_store.sv
// Module rfd_store
// Physical register array. Reads at the end of the read phase and writes at
// the end of the write phase. A missed location reads zero and is never
// written. Assumes loc/wr are held stable from decode through write.
module rfd_store
    import rfd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NP = N_PHYS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase,
    input  loc_t          loc,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bank,
    output logic [DW-1:0] ptr
);

    logic [DW-1:0] mem [NP];

    // Clear on reset; latch the operand in read phase; commit in write phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (phase == PH_READ)
                rdata <= loc.hit ? mem[loc.idx] : '0;
            if (phase == PH_WRITE && wr && loc.hit)
                mem[loc.idx] <= wdata;
        end
    end

    // Expose the bank bit and the pointer for the decoder
    always_comb begin
        bank = mem[IDX_STATUS][BANK_BIT];
        ptr  = mem[IDX_PTR];
    end

    // R9: a missed location returns zero after the read phase
    a_r9_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ && !loc.hit) |=> (rdata == '0));

    // R5: a write that misses leaves status and pointer untouched
    a_r5_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WRITE && !(wr && loc.hit)) |=> ($stable(bank) && $stable(ptr)));

endmodule

// File: rtl/banked_file_decoder.sv
// Module banked_file_decoder
// Top of the banked register file front end. Latches the resolved location
// and write request at the end of decode and drives the four-phase array.
// Assumes the core holds acc_addr/acc_wr valid in phase 0 and wr_data in 3.
module banked_file_decoder
    import rfd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] acc_addr,
    input  logic               acc_wr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [DATA_W-1:0]  rd_data,
    output logic [1:0]         phase_o,
    output logic               bank_sel_o
);

    phase_e              phase;
    loc_t                loc_d;
    loc_t                loc_q;
    logic                wr_q;
    logic                bank;
    logic [DATA_W-1:0]   ptr;

    rfd_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    rfd_decode #(.FW(FIELD_W)) u_decode (
        .field (acc_addr),
        .bank  (bank),
        .ptr   (ptr),
        .loc   (loc_d)
    );

    // Hold the decoded location and request for the rest of the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q <= '0;
            wr_q  <= 1'b0;
        end else if (phase == PH_DECODE) begin
            loc_q <= loc_d;
            wr_q  <= acc_wr;
        end
    end

    rfd_store #(.DW(DATA_W), .NP(N_PHYS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .loc   (loc_q),
        .wr    (wr_q),
        .wdata (wr_data),
        .rdata (rd_data),
        .bank  (bank),
        .ptr   (ptr)
    );

    // Drive the status outputs
    always_comb begin
        phase_o    = phase;
        bank_sel_o = bank;
    end

    // R10: read data only moves on the edge that ends the read phase
    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ALU) |-> $stable(rd_data));

    // R11: the bank only moves on the edge that ends the write phase
    a_r11_bank_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_sel_o) |-> (phase == PH_DECODE));

    // R5: an indirect decode through a null pointer never hits
    a_r5_null_pointer: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE && acc_addr == '0 && ptr[FIELD_W-1:0] == '0)
        |=> !loc_q.hit);

endmodule

// File: tb/banked_file_decoder_tb.sv
module banked_file_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] acc_addr = '0;
    logic       acc_wr = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic [1:0] phase_o;
    logic       bank_sel_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] model [256];
    logic [7:0] last_rd;

    always #10 clk = ~clk;

    banked_file_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_addr   (acc_addr),
        .acc_wr     (acc_wr),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .phase_o    (phase_o),
        .bank_sel_o (bank_sel_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Canonical storage key of an effective address, -1 when unimplemented
    function automatic int canon(input logic [7:0] a);
        int off;
        off = int'(a[6:0]);
        if (off == 2 || off == 3 || off == 4 || off == 10 || off == 11) return off;
        if (off >= 12 && off <= 79) return off;
        if (off == 5 || off == 6 || off == 8 || off == 9) return int'(a);
        return -1;
    endfunction

    function automatic logic [7:0] eff_of(input logic [6:0] f);
        if (f == 7'd0) return model[4];
        return {model[3][5], f};
    endfunction

    // One four-phase access; returns the read operand; updates the model
    task automatic access(input logic [6:0] f, input bit w, input logic [7:0] d,
                          input string req);
        int c;
        logic [7:0] exp;
        while (phase_o != 2'd0) @(negedge clk);
        c   = canon(eff_of(f));
        exp = (c >= 0) ? model[c] : 8'h00;
        acc_addr = f;
        acc_wr   = w;
        wr_data  = ~d;
        @(negedge clk);
        acc_addr = 7'($urandom);
        acc_wr   = 1'b0;
        @(negedge clk);
        chk(phase_o == 2'd2, "R2", phase_o, 2);
        chk(rd_data == exp, req, rd_data, exp);
        last_rd = rd_data;
        @(negedge clk);
        wr_data = d;
        chk(bank_sel_o == model[3][5], "R11", bank_sel_o, model[3][5]);
        @(negedge clk);
        if (w && c >= 0) model[c] = d;
        chk(bank_sel_o == model[3][5], "R11", bank_sel_o, model[3][5]);
        chk(rd_data == last_rd, "R10", rd_data, last_rd);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (4) @(negedge clk);
        chk(phase_o == 2'd0, "R1", phase_o, 0);
        rst_n = 1'b1;
        chk(bank_sel_o == 1'b0, "R1", bank_sel_o, 0);

        // R1: everything reads zero after reset
        access(7'h0C, 0, 8'h00, "R1");
        access(7'h03, 0, 8'h00, "R1");
        access(7'h05, 0, 8'h00, "R1");

        // R6: core register mirrored across banks
        access(7'h0A, 1, 8'h5A, "R6");
        access(7'h03, 1, 8'h20, "R11");      // bank 1 selected
        access(7'h0A, 0, 8'h00, "R6");       // 8Ah reads 5Ah
        // R8: bank-specific storage is separate
        access(7'h05, 1, 8'h33, "R8");       // 85h
        access(7'h09, 1, 8'h44, "R8");       // 89h
        // R7: RAM mirrored
        access(7'h4F, 1, 8'hC3, "R7");       // CFh
        access(7'h03, 1, 8'h00, "R11");      // bank 0, next access uses it
        access(7'h05, 0, 8'h00, "R8");       // 05h still 00h
        access(7'h4F, 0, 8'h00, "R7");       // reads C3h
        // R3: bank bit forms the top address bit
        access(7'h06, 1, 8'h61, "R3");
        access(7'h03, 1, 8'h20, "R11");
        access(7'h06, 0, 8'h00, "R3");       // 86h is not 06h
        // R9: unimplemented locations
        access(7'h07, 1, 8'hFF, "R9");
        access(7'h50, 1, 8'hFF, "R9");
        access(7'h7F, 1, 8'hFF, "R9");
        access(7'h01, 1, 8'hFF, "R9");
        access(7'h07, 0, 8'h00, "R9");
        access(7'h7F, 0, 8'h00, "R9");
        // R4: indirect ignores the bank bit
        access(7'h03, 1, 8'h00, "R11");
        access(7'h04, 1, 8'h85, "R4");
        access(7'h00, 0, 8'h00, "R4");       // reads 33h from 85h
        access(7'h04, 1, 8'h09, "R4");
        access(7'h00, 1, 8'h77, "R4");       // 09h bank 0
        access(7'h09, 0, 8'h00, "R4");
        // R5: null pointers
        access(7'h04, 1, 8'h00, "R5");
        access(7'h00, 1, 8'hAB, "R5");
        access(7'h00, 0, 8'h00, "R5");
        access(7'h04, 1, 8'h80, "R5");
        access(7'h00, 1, 8'hCD, "R5");
        access(7'h04, 0, 8'h00, "R5");       // still 80h
        // Indirect write into the pointer itself, then follow it
        access(7'h04, 1, 8'h04, "R4");
        access(7'h00, 1, 8'h8C, "R4");
        access(7'h00, 0, 8'h00, "R4");       // through 8Ch, mirror of 0Ch
        // Status write through the pointer flips bank for the next access
        access(7'h04, 1, 8'h83, "R11");
        access(7'h00, 1, 8'h20, "R11");
        access(7'h05, 0, 8'h00, "R11");      // bank 1, 85h

        // Random traffic
        for (int n = 0; n < 600; n++) begin
            int sel;
            logic [6:0] f;
            sel = int'($urandom_range(0, 9));
            if (sel == 0)      f = 7'h00;
            else if (sel == 1) f = 7'h03;
            else if (sel == 2) f = 7'h04;
            else               f = 7'($urandom);
            access(f, bit'($urandom_range(0, 1)), 8'($urandom), "R3");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule